// File: doc/BRIEF.md
# Card Command Issue and Status Unit

This unit sits between a 16-bit register port and a card-side request/response channel. Software loads a 32-bit command argument in two 16-bit halves and then writes a command word. The unit splits that word into its fields and promotes the response kind when the busy flag asks for it. It then sends a single-cycle request towards the card engine. When the command carries data, it also sends a pulse that resets the data buffer pointers and starts the transfer.

When the card engine answers, the unit records the outcome in a sticky status register. The answer is either a response or a timeout. Software clears status bits by writing ones to them. On a good answer the unit captures up to eight response halfwords. A 15-bit enable mask selects which status bits drive the single interrupt line. Only one command may be outstanding at a time. While one is outstanding, and also while the controller enable bit is clear, command writes do nothing.

Top module: `sd_cmd_unit`

## Requirements
- R1: A command word accepted at address 0 is decoded as index = bits 5:0, init = bit 7, response kind = bits 10:8, busy = bit 11, command type = bits 13:12, direction = bit 15. In the cycle after the write, these values appear on the request outputs while `cardReqValid` is high for exactly one cycle. Address 0 reads back the last accepted word.
- R2: Response kinds are coded 0 none, 1 R1, 2 R2, 3 R3 and 6 R6. A kind of 1 with the busy bit set is sent as 7 (R1 with busy). Every other kind is sent unchanged.
- R3: A command of type 3 (addressed with data) raises `xferStart` for one cycle, together with the request. Types 0 (broadcast), 1 (broadcast with response) and 2 (addressed, no data) never raise it.
- R4: Bit 0 of the control register at address 3 is the controller enable. While it is 0, a command write sends no request, raises no `xferStart`, and leaves the last-command readback, the status and the response halfwords unchanged.
- R5: An accepted command clears all eight response halfwords (addresses 8 to 15). If the command's response kind is nonzero and the answer is not a timeout, halfword k is loaded from `cardRespData[16k+15:16k]`.
- R6: A timeout answer sets status bit 7.
- R7: A good answer to command index 12 sets status bits 0 and 2. A good answer to any other index sets status bit 0 only.
- R8: The status register at address 4 clears each bit written as 1 and keeps the others. A bit set by an answer in the same cycle stays set.
- R9: The interrupt enable register at address 5 stores bits 14:0 and reads bit 15 as 0. `irq` is high exactly when some status bit and the same enable bit are both 1.
- R10: Address 1 writes only argument bits 15:0 and address 2 writes only bits 31:16. The request carries the 32-bit argument as it stands when the command is accepted.
- R11: While a command is outstanding, further command writes are rejected (no request, readback unchanged) until its answer arrives. An answer that arrives when nothing is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational on regAddr) |
| cardReqValid | output | 1 | One-cycle command request to the card engine |
| cardReqIndex | output | 6 | Command index |
| cardReqInit | output | 1 | Initialisation sequence flag |
| cardReqRespType | output | 3 | Effective response kind (7 = R1 with busy) |
| cardReqCmdType | output | 2 | Command type |
| cardReqDir | output | 1 | Data direction |
| cardReqArg | output | 32 | Command argument |
| xferStart | output | 1 | Pulse that clears buffer pointers and starts a data transfer |
| cardRespValid | input | 1 | Answer strobe from the card engine |
| cardRespTimeout | input | 1 | Answer is a timeout |
| cardRespData | input | 128 | Response halfwords, halfword k at bits 16k+15:16k |
| irq | output | 1 | Interrupt line |

## Verification
The bench aims at the index-12 answer. If that case were mishandled, status would read 0x0001 instead of 0x0005. It also aims at the busy promotion: a design that forgot it would send kind 1 instead of 7, and one that applied it too widely would change R2 or R3 requests. Command writes go in while the unit is disabled and while a command is outstanding. A design that leaked either write would show a second request pulse or a changed readback. The bench checks that a timeout leaves the response halfwords at zero, and that writing ones to status clears only those bits, so a plain store instead of write-one-to-clear shows up as corrupted flags or a wrong `irq`.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int HALF_W     = 16;
  localparam int ADDR_W     = 4;
  localparam int RSP_HALVES = 8;
  localparam int RSP_W      = RSP_HALVES * HALF_W;
  localparam int IDX_W      = 6;

  // register word addresses
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_ARG_LO = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_ARG_HI = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 4'd5;

  // response kind codes
  localparam logic [2:0] RSP_NONE = 3'd0;
  localparam logic [2:0] RSP_R1   = 3'd1;
  localparam logic [2:0] RSP_R1B  = 3'd7;

  localparam logic [1:0] TYPE_DATA = 2'd3;

  // status bit positions
  localparam int STAT_DONE    = 0;
  localparam int STAT_STOP    = 2;
  localparam int STAT_TIMEOUT = 7;

  localparam logic [IDX_W-1:0] STOP_INDEX = 6'd12;
  localparam logic [HALF_W-1:0] MASK_KEEP = 16'h7fff;

  typedef struct packed {
    logic issue;     // command accepted this cycle
    logic complete;  // good answer this cycle
    logic timeout;   // timeout answer this cycle
    logic stopCmd;   // good answer belongs to the stop command
    logic capture;   // load response halfwords
  } cmdStrobe_t;

endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [HALF_W-1:0]     regWrData,
  input  logic                  ctrlEnable,
  input  logic [2*HALF_W-1:0]   argWord,
  input  logic                  cardRespValid,
  input  logic                  cardRespTimeout,
  output cmdStrobe_t            strobe,
  output logic                  cardReqValid,
  output logic [IDX_W-1:0]      cardReqIndex,
  output logic                  cardReqInit,
  output logic [2:0]            cardReqRespType,
  output logic [1:0]            cardReqCmdType,
  output logic                  cardReqDir,
  output logic [2*HALF_W-1:0]   cardReqArg,
  output logic                  xferStart
);

  logic             pending;
  logic [IDX_W-1:0] activeIdx;
  logic [2:0]       activeResp;
  logic             cmdWrite;
  logic             accept;
  logic             respAccept;
  logic [2:0]       rawResp;
  logic [2:0]       effResp;
  logic             unusedBits;

  assign unusedBits = ^{regWrData[14], regWrData[6]};

  assign cmdWrite   = regWrEn && (regAddr == ADDR_CMD);
  assign accept     = cmdWrite && ctrlEnable && !pending;
  assign respAccept = cardRespValid && pending;

  assign rawResp = regWrData[10:8];
  assign effResp = (rawResp == RSP_R1 && regWrData[11]) ? RSP_R1B : rawResp;

  always_comb begin
    strobe          = '0;
    strobe.issue    = accept;
    strobe.timeout  = respAccept && cardRespTimeout;
    strobe.complete = respAccept && !cardRespTimeout;
    strobe.stopCmd  = strobe.complete && (activeIdx == STOP_INDEX);
    strobe.capture  = strobe.complete && (activeResp != RSP_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending         <= 1'b0;
      activeIdx       <= '0;
      activeResp      <= '0;
      cardReqValid    <= 1'b0;
      cardReqIndex    <= '0;
      cardReqInit     <= 1'b0;
      cardReqRespType <= '0;
      cardReqCmdType  <= '0;
      cardReqDir      <= 1'b0;
      cardReqArg      <= '0;
      xferStart       <= 1'b0;
    end else begin
      cardReqValid <= accept;
      xferStart    <= accept && (regWrData[13:12] == TYPE_DATA);
      if (accept) begin
        pending         <= 1'b1;
        activeIdx       <= regWrData[5:0];
        activeResp      <= effResp;
        cardReqIndex    <= regWrData[5:0];
        cardReqInit     <= regWrData[7];
        cardReqRespType <= effResp;
        cardReqCmdType  <= regWrData[13:12];
        cardReqDir      <= regWrData[15];
        cardReqArg      <= argWord;
      end else if (respAccept) begin
        pending <= 1'b0;
      end
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid |=> !cardReqValid);

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid |-> pending);

  a_r4_disabled_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !ctrlEnable) |=> (!cardReqValid && !xferStart));

  a_r2_busy_promotion: assert property (@(posedge clk) disable iff (!rstN)
    (accept && regWrData[10:8] == 3'd1 && regWrData[11]) |=> (cardReqRespType == 3'd7));

  a_r3_xfer_with_data: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> (cardReqValid && cardReqCmdType == 2'd3));

endmodule

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
  import sd_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [HALF_W-1:0]     regWrData,
  input  cmdStrobe_t            strobe,
  input  logic [RSP_W-1:0]      cardRespData,
  output logic [HALF_W-1:0]     regRdData,
  output logic                  ctrlEnable,
  output logic [2*HALF_W-1:0]   argWord,
  output logic                  irq
);

  logic [HALF_W-1:0] argLo;
  logic [HALF_W-1:0] argHi;
  logic [HALF_W-1:0] lastCmd;
  logic [HALF_W-1:0] status;
  logic [HALF_W-1:0] statusNext;
  logic [HALF_W-1:0] mask;
  logic [RSP_W-1:0]  rspFlat;
  logic              wrStatus;

  assign wrStatus = regWrEn && (regAddr == ADDR_STATUS);
  assign argWord  = {argHi, argLo};

  always_comb begin
    statusNext = status;
    if (wrStatus)
      statusNext = statusNext & ~regWrData;
    if (strobe.timeout)
      statusNext[STAT_TIMEOUT] = 1'b1;
    if (strobe.complete)
      statusNext[STAT_DONE] = 1'b1;
    if (strobe.stopCmd)
      statusNext[STAT_STOP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argLo      <= '0;
      argHi      <= '0;
      lastCmd    <= '0;
      status     <= '0;
      mask       <= '0;
      ctrlEnable <= 1'b0;
    end else begin
      status <= statusNext;
      if (strobe.issue)
        lastCmd <= regWrData;
      if (regWrEn) begin
        unique case (regAddr)
          ADDR_ARG_LO: argLo      <= regWrData;
          ADDR_ARG_HI: argHi      <= regWrData;
          ADDR_CTRL:   ctrlEnable <= regWrData[0];
          ADDR_MASK:   mask       <= regWrData & MASK_KEEP;
          default: ;
        endcase
      end
    end
  end

  for (genvar gi = 0; gi < RSP_HALVES; gi++) begin : g_rsp
    logic [HALF_W-1:0] half;
    always_ff @(posedge clk) begin
      if (!rstN)
        half <= '0;
      else if (strobe.issue)
        half <= '0;
      else if (strobe.capture)
        half <= cardRespData[gi*HALF_W +: HALF_W];
    end
    assign rspFlat[gi*HALF_W +: HALF_W] = half;

    a_r5_clear_on_issue: assert property (@(posedge clk) disable iff (!rstN)
      strobe.issue |=> (half == '0));
  end

  always_comb begin
    regRdData = '0;
    if (regAddr[ADDR_W-1]) begin
      regRdData = rspFlat[regAddr[ADDR_W-2:0]*HALF_W +: HALF_W];
    end else begin
      unique case (regAddr)
        ADDR_CMD:    regRdData = lastCmd;
        ADDR_ARG_LO: regRdData = argLo;
        ADDR_ARG_HI: regRdData = argHi;
        ADDR_CTRL:   regRdData = {{(HALF_W-1){1'b0}}, ctrlEnable};
        ADDR_STATUS: regRdData = status;
        ADDR_MASK:   regRdData = mask;
        default:     regRdData = '0;
      endcase
    end
  end

  assign irq = |(status & mask);

  a_r6_timeout_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobe.timeout |=> status[STAT_TIMEOUT]);

  a_r7_stop_pattern: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stopCmd |=> (status[STAT_DONE] && status[STAT_STOP]));

  a_r8_write_one_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && !strobe.timeout && !strobe.complete) |=> ((status & $past(regWrData)) == '0));

  a_r9_mask_top_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_MASK) |=> !mask[HALF_W-1]);

endmodule

// File: rtl/sd_cmd_unit.sv
module sd_cmd_unit
  import sd_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [HALF_W-1:0]    regWrData,
  output logic [HALF_W-1:0]    regRdData,
  output logic                 cardReqValid,
  output logic [IDX_W-1:0]     cardReqIndex,
  output logic                 cardReqInit,
  output logic [2:0]           cardReqRespType,
  output logic [1:0]           cardReqCmdType,
  output logic                 cardReqDir,
  output logic [2*HALF_W-1:0]  cardReqArg,
  output logic                 xferStart,
  input  logic                 cardRespValid,
  input  logic                 cardRespTimeout,
  input  logic [RSP_W-1:0]     cardRespData,
  output logic                 irq
);

  cmdStrobe_t            strobe;
  logic                  ctrlEnable;
  logic [2*HALF_W-1:0]   argWord;

  sd_cmd_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .regWrEn         (regWrEn),
    .regAddr         (regAddr),
    .regWrData       (regWrData),
    .ctrlEnable      (ctrlEnable),
    .argWord         (argWord),
    .cardRespValid   (cardRespValid),
    .cardRespTimeout (cardRespTimeout),
    .strobe          (strobe),
    .cardReqValid    (cardReqValid),
    .cardReqIndex    (cardReqIndex),
    .cardReqInit     (cardReqInit),
    .cardReqRespType (cardReqRespType),
    .cardReqCmdType  (cardReqCmdType),
    .cardReqDir      (cardReqDir),
    .cardReqArg      (cardReqArg),
    .xferStart       (xferStart)
  );

  sd_cmd_regs u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .strobe       (strobe),
    .cardRespData (cardRespData),
    .regRdData    (regRdData),
    .ctrlEnable   (ctrlEnable),
    .argWord      (argWord),
    .irq          (irq)
  );

endmodule

// File: tb/sd_cmd_unit_test.sv
module sd_cmd_unit_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [15:0]  regWrData = '0;
  logic [15:0]  regRdData;
  logic         cardReqValid;
  logic [5:0]   cardReqIndex;
  logic         cardReqInit;
  logic [2:0]   cardReqRespType;
  logic [1:0]   cardReqCmdType;
  logic         cardReqDir;
  logic [31:0]  cardReqArg;
  logic         xferStart;
  logic         cardRespValid = 1'b0;
  logic         cardRespTimeout = 1'b0;
  logic [127:0] cardRespData = '0;
  logic         irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // bench model
  logic [15:0] mStatus = 0, mMask = 0, mArgLo = 0, mArgHi = 0, mLast = 0;
  logic        mEnable = 0, mPending = 0;
  logic [5:0]  mIdx = 0;
  logic [2:0]  mResp = 0;
  logic [15:0] mRsp [8];

  always #2.5 clk = ~clk;

  sd_cmd_unit uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expResp(input logic [15:0] w);
    return (w[10:8] == 3'd1 && w[11]) ? 3'd7 : w[10:8];
  endfunction

  function automatic logic [15:0] doneBits(input logic [5:0] idx);
    return (idx == 6'd12) ? 16'h0005 : 16'h0001;
  endfunction

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [15:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic checkRegs(input string tag);
    logic [15:0] v;
    readReg(4'd4, v);  chk({tag, " R8 status"}, v, mStatus);
    readReg(4'd5, v);  chk({tag, " R9 mask"}, v, mMask);
    chk({tag, " R9 irq"}, irq, |(mStatus & mMask));
    readReg(4'd0, v);  chk({tag, " R1 last command"}, v, mLast);
    for (int k = 0; k < 8; k++) begin
      readReg(4'(8 + k), v);
      chk({tag, " R5 response halfword"}, v, mRsp[k]);
    end
  endtask

  task automatic setMask(input logic [15:0] d);
    writeReg(4'd5, d);
    mMask = d & 16'h7fff;
  endtask

  task automatic clearStatus(input logic [15:0] d);
    writeReg(4'd4, d);
    mStatus = mStatus & ~d;
  endtask

  task automatic setArg(input bit hi, input logic [15:0] d);
    logic [15:0] v;
    writeReg(hi ? 4'd2 : 4'd1, d);
    if (hi) mArgHi = d; else mArgLo = d;
    readReg(4'd1, v); chk("R10 argument low half", v, mArgLo);
    readReg(4'd2, v); chk("R10 argument high half", v, mArgHi);
  endtask

  task automatic issue(input logic [15:0] w);
    bit acc;
    acc = mEnable && !mPending;
    writeReg(4'd0, w);
    if (acc) begin
      chk("R1 request pulse", cardReqValid, 1'b1);
      chk("R1 index field", cardReqIndex, w[5:0]);
      chk("R1 init field", cardReqInit, w[7]);
      chk("R1 type field", cardReqCmdType, w[13:12]);
      chk("R1 direction field", cardReqDir, w[15]);
      chk("R2 response kind", cardReqRespType, expResp(w));
      chk("R3 transfer start", xferStart, w[13:12] == 2'd3);
      chk("R10 request argument", cardReqArg, {mArgHi, mArgLo});
      mLast = w; mPending = 1'b1; mIdx = w[5:0]; mResp = expResp(w);
      for (int k = 0; k < 8; k++) mRsp[k] = '0;
      @(negedge clk);
      chk("R1 pulse is one cycle", cardReqValid, 1'b0);
    end else begin
      chk(mEnable ? "R11 rejected while outstanding" : "R4 ignored while disabled",
          {cardReqValid, xferStart}, 2'b00);
    end
  endtask

  task automatic respond(input bit tmo, input logic [127:0] data);
    @(negedge clk);
    cardRespValid = 1'b1; cardRespTimeout = tmo; cardRespData = data;
    @(negedge clk);
    cardRespValid = 1'b0; cardRespTimeout = 1'b0;
    if (mPending) begin
      mPending = 1'b0;
      if (tmo) mStatus = mStatus | 16'h0080;
      else begin
        mStatus = mStatus | doneBits(mIdx);
        if (mResp != 3'd0)
          for (int k = 0; k < 8; k++) mRsp[k] = data[k*16 +: 16];
      end
    end
  endtask

  function automatic logic [127:0] rndData();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) mRsp[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 reset request idle", cardReqValid, 1'b0);
    chk("R9 reset irq low", irq, 1'b0);
    checkRegs("reset");

    // disabled: command ignored (R4)
    issue(16'hB311);
    checkRegs("R4 after disabled write");

    writeReg(4'd3, 16'h0001); mEnable = 1'b1;
    readReg(4'd3, v); chk("R4 enable readback", v, 16'h0001);

    // R10 halves
    setArg(1'b0, 16'h1234);
    setArg(1'b1, 16'hABCD);
    setArg(1'b0, 16'h5678);

    // stop command, R1 with busy -> R1b (R2, R7), second write rejected (R11)
    issue(16'h2919);   // type 2, busy, R1, idx 25? adjust below
    respond(1'b0, rndData());
    clearStatus(16'hFFFF);
    issue(16'h290C);   // idx 12, R1, busy, type 2
    issue(16'h0105);   // R11: rejected
    checkRegs("R11 while outstanding");
    respond(1'b0, rndData());
    checkRegs("R7 stop command answer");
    respond(1'b0, rndData());   // R11: stray answer ignored
    checkRegs("R11 stray answer");

    // mask and W1C (R8, R9)
    setMask(16'hFFFF);
    checkRegs("R9 mask top bit");
    clearStatus(16'h0001);
    checkRegs("R8 partial clear");
    setMask(16'h0001);
    checkRegs("R9 irq masked off");

    // data command R2 (R3, R5)
    issue(16'hB211);
    respond(1'b0, rndData());
    checkRegs("R5 capture");
    // R3 response-type with busy is not promoted
    issue(16'h0B03);
    respond(1'b0, rndData());
    checkRegs("R2 R3 not promoted");
    // timeout leaves response clear (R6, R5)
    issue(16'h3611);
    respond(1'b1, rndData());
    checkRegs("R6 timeout");
    // no-response command leaves halfwords zero
    issue(16'h0000);
    respond(1'b0, rndData());
    checkRegs("R5 no response kind");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: setArg($urandom_range(0, 1) == 1, 16'($urandom));
        1: setMask(16'($urandom));
        2: clearStatus(16'($urandom));
        3: begin writeReg(4'd3, 16'($urandom_range(0, 7)) | 16'h0001); mEnable = 1'b1; end
        4: if ($urandom_range(0, 3) == 0) begin writeReg(4'd3, 16'h0000); mEnable = 1'b0; end
        5: respond($urandom_range(0, 3) == 0, rndData());
        default: begin
          logic [15:0] w;
          w = 16'($urandom);
          if ($urandom_range(0, 3) == 0) w[5:0] = 6'd12;
          if ($urandom_range(0, 2) == 0) w[10:8] = 3'd1;
          issue(w);
          if ($urandom_range(0, 3) != 0) begin
            repeat ($urandom_range(0, 3)) @(negedge clk);
            respond($urandom_range(0, 3) == 0, rndData());
          end
        end
      endcase
      checkRegs("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule